// File: doc/BRIEF.md
# Microcode Control Sequencer

This block is the control unit of a small 16-bit load/store processor. It holds a fixed microprogram in a control store, keeps a micro-address register, and drives each step's control fields out to the datapath. These fields are the destination register strobe, the internal bus source, the register-file select, the ALU second-operand mux, the ALU operation, the memory command and a PC-increment strobe. The datapath, memory and register file sit outside it. The datapath supplies the opcode field, the extended-opcode field and the three-bit condition field of the current instruction. It also supplies the zero (Z) and sign (S) flags and a memory-ready handshake.

Each instruction starts with a shared fetch routine. The sequencer then jumps to the routine for the opcode, or for the extended opcode when the opcode is all ones. Every routine ends by going back to fetch. Any step that issues a memory command repeats until ready is seen. A conditional jump evaluates its condition from Z and S. The register-plus-displacement add routine selects the instruction's 3-bit displacement onto the bus and routes the bus into the ALU's second operand. Undefined codes and the trap instruction go to one shared step that sets a sticky exception output.

Top module: `useq_ctrl`

## Requirements
- R1: Reset (asynchronous, active low) forces micro-address 0 and clears `exc_o`. Micro-address 0 drives dst=1 (MAR) and src=1 (PC), with all other fields 0.
- R2: Fetch runs at addresses 0, 1 and 2. Address 1 drives mem=1 (read). Address 2 drives dst=3 (IR), src=4 (MDR) and `pc_inc_o`=1, and then jumps to the routine for the decoded instruction.
- R3: Opcode 0 enters address 3 (load). Opcode 1 enters 6 (store), 2 enters 24 (jmp) and 3 enters 26 (jal).
- R4: Opcode 7 dispatches on xop. The targets are mov→17, loadr→10, storer→13, add→19, cmp→21, inc→22, jr→28 and addd→29, for xop 0,1,2,3,4,5,6,7 respectively.
- R5: Opcodes 4 to 6, xop 9 to 15, and trap (xop 8) all enter address 34, which drives no datapath field. From the next cycle `exc_o` reads 1 and stays at 1 until reset. Control then returns to address 0.
- R6: A step with a memory command (mem=1 read, mem=2 write) at address 1, 4, 8, 11, 15 or 31 keeps its address and command while `mem_rdy_i` is 0. It advances one address on the edge where `mem_rdy_i` is 1. In any other step, `mem_rdy_i` has no effect.
- R7: jmp (address 24, all fields 0) tests the condition field against the flags. The codes are 0 always, 1 Z=1, 2 Z=0, 3 S=1, 4 S=1 or Z=1, 5 S=0 or Z=0, 6 S=0, and 7 never. If the test is true, the next step is 25 with dst=4 (PC) and src=2 (address field), followed by 0. If it is false, the next step is 0.
- R8: addd runs these steps, then returns to 0:
  - 29: src=6 (displacement), rsel=3 (r2), mux=1 (bus), alu=2 (add).
  - 30: dst=1, src=5 (T).
  - 31: read, waiting for ready.
  - 32: src=4, rsel=2 (r1), mux=1, alu=2.
  - 33: dst=5 (register), src=5, rsel=2.
- R9: jal runs 26 (dst=5, src=1, rsel=1 (r0)), then 27 (dst=4, src=2), then 0. jr runs 28 (dst=4, src=3 (register), rsel=2), then 0.
- R10: load runs 3 (dst=1, src=2), a read at 4, then 5 (dst=5, src=4, rsel=1). store runs 6 (dst=1, src=2), 7 (dst=2 (MDR), src=3, rsel=1), a write at 8, then an empty step 9. loadr runs 10 (dst=1, src=3, rsel=2), a read at 11, then 12 (dst=5, src=4, rsel=3). storer runs 13 (dst=1, src=3, rsel=3), 14 (dst=2, src=3, rsel=2), a write at 15, then an empty step 16. Each then returns to 0.
- R11: mov runs 17 (rsel=2, alu=1 (pass)), then 18 (dst=5, src=5, rsel=3). add runs 19 (rsel=4 (r1 and r2), alu=2), then 20 (dst=5, src=5, rsel=2). cmp runs a single step 21 (rsel=4, alu=3 (subtract)). inc runs 22 (rsel=2, alu=4 (increment)), then 23 (dst=5, src=5, rsel=2). Each then returns to 0. In every step except 29 and 32, mux=0 (register operand).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ir_op_i | input | OP_W (3) | Opcode field of the instruction register |
| ir_xop_i | input | XOP_W (4) | Extended-opcode field of the instruction register |
| ir_cc_i | input | CC_W (3) | Condition / r0 field of the instruction register |
| flag_z_i | input | 1 | Zero flag |
| flag_s_i | input | 1 | Sign flag |
| mem_rdy_i | input | 1 | Memory ready |
| uaddr_o | output | 6 | Current micro-address |
| dst_o | output | 3 | Destination strobe code |
| src_o | output | 3 | Bus source code |
| rsel_o | output | 3 | Register-file select code |
| opmux_o | output | 1 | ALU second operand: 0 register, 1 bus |
| alu_o | output | 3 | ALU operation code |
| mem_o | output | 2 | Memory command: 0 idle, 1 read, 2 write |
| pc_inc_o | output | 1 | PC increment strobe |
| exc_o | output | 1 | Sticky illegal/trap indicator |

## Verification
The bench exercises every condition code against all four Z/S combinations. It checks both the taken path through 25 and the untaken return to 0, because a swapped flag test or an off-by-one condition code would either skip the PC load or perform it wrongly. Memory steps are run with zero, one and several wait cycles, and `mem_rdy_i` is toggled during non-memory steps. This catches a sequencer that advances early, that drops its command while waiting, or that stalls on ready outside a wait step. Each undefined opcode, each undefined xop and trap is issued, and `exc_o` is watched for its one-cycle delay, its stickiness across later instructions and its clearing by reset. The addd routine is checked step by step, so a missing displacement source or bus mux setting shows up as a field mismatch at 29 or 32.

// File: rtl/useq_pkg.sv
package useq_pkg;

   localparam int unsigned UA_W = 6;

   typedef enum logic [2:0] {DST_NONE, DST_MAR, DST_MDR, DST_IR, DST_PC, DST_REG} dst_e;
   typedef enum logic [2:0] {SRC_NONE, SRC_PC, SRC_ADS, SRC_REG, SRC_MDR, SRC_T, SRC_DISP} src_e;
   typedef enum logic [2:0] {RS_NONE, RS_R0, RS_R1, RS_R2, RS_R12} rsel_e;
   typedef enum logic [0:0] {MX_REG, MX_BUS} mux_e;
   typedef enum logic [2:0] {AL_NOP, AL_PASS, AL_ADD, AL_SUB, AL_INC} alu_e;
   typedef enum logic [1:0] {MC_IDLE, MC_RD, MC_WR} mem_e;
   typedef enum logic [1:0] {MS_NONE, MS_PCINC, MS_EXC} misc_e;
   typedef enum logic [2:0] {SQ_NEXT, SQ_WAIT, SQ_DECODE, SQ_TEST, SQ_JUMP} seq_e;

   typedef struct packed {
      dst_e            dst;
      src_e            src;
      rsel_e           rsel;
      mux_e            mux;
      alu_e            alu;
      mem_e            mem;
      misc_e           misc;
      seq_e            seq;
      logic [UA_W-1:0] tgt;
   } uword_t;

   // routine entry points in the control store
   localparam int unsigned UA_FETCH  = 0;
   localparam int unsigned UA_LOAD   = 3;
   localparam int unsigned UA_STORE  = 6;
   localparam int unsigned UA_LOADR  = 10;
   localparam int unsigned UA_STORER = 13;
   localparam int unsigned UA_MOV    = 17;
   localparam int unsigned UA_ADD    = 19;
   localparam int unsigned UA_CMP    = 21;
   localparam int unsigned UA_INC    = 22;
   localparam int unsigned UA_JMP    = 24;
   localparam int unsigned UA_JAL    = 26;
   localparam int unsigned UA_JR     = 28;
   localparam int unsigned UA_ADDD   = 29;
   localparam int unsigned UA_EXC    = 34;
   localparam int unsigned CS_DEPTH  = 35;

   function automatic uword_t mk(dst_e d, src_e s, rsel_e r, mux_e m, alu_e a,
                                 mem_e mc, misc_e ms, seq_e sq, int unsigned t);
      uword_t w;
      w.dst  = d;
      w.src  = s;
      w.rsel = r;
      w.mux  = m;
      w.alu  = a;
      w.mem  = mc;
      w.misc = ms;
      w.seq  = sq;
      w.tgt  = UA_W'(t);
      return w;
   endfunction

   // step that only returns to fetch
   function automatic uword_t back();
      return mk(DST_NONE, SRC_NONE, RS_NONE, MX_REG, AL_NOP, MC_IDLE, MS_NONE, SQ_JUMP, UA_FETCH);
   endfunction

   function automatic uword_t plain(dst_e d, src_e s, rsel_e r, seq_e sq);
      return mk(d, s, r, MX_REG, AL_NOP, MC_IDLE, MS_NONE, sq, UA_FETCH);
   endfunction

   function automatic uword_t memw(mem_e mc);
      return mk(DST_NONE, SRC_NONE, RS_NONE, MX_REG, AL_NOP, mc, MS_NONE, SQ_WAIT, UA_FETCH);
   endfunction

   function automatic uword_t aluw(src_e s, rsel_e r, mux_e m, alu_e a, seq_e sq);
      return mk(DST_NONE, s, r, m, a, MC_IDLE, MS_NONE, sq, UA_FETCH);
   endfunction

   function automatic uword_t cs_lookup(int unsigned a);
      case (a)
         0:  return plain(DST_MAR, SRC_PC,  RS_NONE, SQ_NEXT);
         1:  return memw(MC_RD);
         2:  return mk(DST_IR, SRC_MDR, RS_NONE, MX_REG, AL_NOP, MC_IDLE, MS_PCINC, SQ_DECODE, UA_FETCH);
         3:  return plain(DST_MAR, SRC_ADS, RS_NONE, SQ_NEXT);
         4:  return memw(MC_RD);
         5:  return plain(DST_REG, SRC_MDR, RS_R0,   SQ_JUMP);
         6:  return plain(DST_MAR, SRC_ADS, RS_NONE, SQ_NEXT);
         7:  return plain(DST_MDR, SRC_REG, RS_R0,   SQ_NEXT);
         8:  return memw(MC_WR);
         9:  return back();
         10: return plain(DST_MAR, SRC_REG, RS_R1,   SQ_NEXT);
         11: return memw(MC_RD);
         12: return plain(DST_REG, SRC_MDR, RS_R2,   SQ_JUMP);
         13: return plain(DST_MAR, SRC_REG, RS_R2,   SQ_NEXT);
         14: return plain(DST_MDR, SRC_REG, RS_R1,   SQ_NEXT);
         15: return memw(MC_WR);
         16: return back();
         17: return aluw(SRC_NONE, RS_R1,  MX_REG, AL_PASS, SQ_NEXT);
         18: return plain(DST_REG, SRC_T,   RS_R2,   SQ_JUMP);
         19: return aluw(SRC_NONE, RS_R12, MX_REG, AL_ADD,  SQ_NEXT);
         20: return plain(DST_REG, SRC_T,   RS_R1,   SQ_JUMP);
         21: return aluw(SRC_NONE, RS_R12, MX_REG, AL_SUB,  SQ_JUMP);
         22: return aluw(SRC_NONE, RS_R1,  MX_REG, AL_INC,  SQ_NEXT);
         23: return plain(DST_REG, SRC_T,   RS_R1,   SQ_JUMP);
         24: return plain(DST_NONE, SRC_NONE, RS_NONE, SQ_TEST);
         25: return plain(DST_PC,  SRC_ADS, RS_NONE, SQ_JUMP);
         26: return plain(DST_REG, SRC_PC,  RS_R0,   SQ_NEXT);
         27: return plain(DST_PC,  SRC_ADS, RS_NONE, SQ_JUMP);
         28: return plain(DST_PC,  SRC_REG, RS_R1,   SQ_JUMP);
         29: return aluw(SRC_DISP, RS_R2,  MX_BUS, AL_ADD,  SQ_NEXT);
         30: return plain(DST_MAR, SRC_T,   RS_NONE, SQ_NEXT);
         31: return memw(MC_RD);
         32: return aluw(SRC_MDR,  RS_R1,  MX_BUS, AL_ADD,  SQ_NEXT);
         33: return plain(DST_REG, SRC_T,   RS_R1,   SQ_JUMP);
         34: return mk(DST_NONE, SRC_NONE, RS_NONE, MX_REG, AL_NOP, MC_IDLE, MS_EXC, SQ_JUMP, UA_FETCH);
         default: return back();
      endcase
   endfunction

   // primary opcode entry; the all-ones opcode is resolved through the xop table
   function automatic int unsigned op_entry(int unsigned op);
      case (op)
         0: return UA_LOAD;
         1: return UA_STORE;
         2: return UA_JMP;
         3: return UA_JAL;
         default: return UA_EXC;
      endcase
   endfunction

   function automatic int unsigned xop_entry(int unsigned xop);
      case (xop)
         0: return UA_MOV;
         1: return UA_LOADR;
         2: return UA_STORER;
         3: return UA_ADD;
         4: return UA_CMP;
         5: return UA_INC;
         6: return UA_JR;
         7: return UA_ADDD;
         default: return UA_EXC;
      endcase
   endfunction

endpackage

// File: rtl/useq_store.sv
module useq_store
   import useq_pkg::*;
#(
   parameter int unsigned DEPTH = CS_DEPTH,
   parameter bit          TABLE = 1'b1
) (
   input  logic [UA_W-1:0] addr_i,
   output uword_t          word_o
);

   localparam logic [UA_W-1:0] LAST = UA_W'(DEPTH - 1);

   generate
      if (TABLE) begin : g_table
         uword_t rom [DEPTH];
         for (genvar i = 0; i < DEPTH; i++) begin : g_fill
            assign rom[i] = cs_lookup(i);
         end
         assign word_o = (addr_i <= LAST) ? rom[addr_i] : back();
      end else begin : g_direct
         assign word_o = cs_lookup({{(32-UA_W){1'b0}}, addr_i});
      end
   endgenerate

endmodule

// File: rtl/useq_dispatch.sv
module useq_dispatch
   import useq_pkg::*;
#(
   parameter int unsigned OP_W  = 3,
   parameter int unsigned XOP_W = 4
) (
   input  logic [OP_W-1:0]  op_i,
   input  logic [XOP_W-1:0] xop_i,
   output logic [UA_W-1:0]  tgt_o
);

   localparam int unsigned N_OP  = 1 << OP_W;
   localparam int unsigned N_XOP = 1 << XOP_W;
   localparam logic [OP_W-1:0] OP_EXT = '1;

   logic [UA_W-1:0] op_tab  [N_OP];
   logic [UA_W-1:0] xop_tab [N_XOP];

   generate
      for (genvar i = 0; i < N_OP; i++) begin : g_op
         assign op_tab[i] = UA_W'(op_entry(i));
      end
      for (genvar j = 0; j < N_XOP; j++) begin : g_xop
         assign xop_tab[j] = UA_W'(xop_entry(j));
      end
   endgenerate

   assign tgt_o = (op_i == OP_EXT) ? xop_tab[xop_i] : op_tab[op_i];

endmodule

// File: rtl/useq_cond.sv
module useq_cond #(
   parameter int unsigned CC_W = 3
) (
   input  logic [CC_W-1:0] code_i,
   input  logic            z_i,
   input  logic            s_i,
   output logic            ok_o
);

   logic [31:0] code;
   assign code = 32'(code_i);

   always_comb begin
      case (code)
         0:       ok_o = 1'b1;
         1:       ok_o = z_i;
         2:       ok_o = ~z_i;
         3:       ok_o = s_i;
         4:       ok_o = s_i | z_i;
         5:       ok_o = ~s_i | ~z_i;
         6:       ok_o = ~s_i;
         default: ok_o = 1'b0;
      endcase
   end

endmodule

// File: rtl/useq_ctrl.sv
module useq_ctrl
   import useq_pkg::*;
#(
   parameter int unsigned OP_W     = 3,
   parameter int unsigned XOP_W    = 4,
   parameter int unsigned CC_W     = 3,
   parameter bit          CS_TABLE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [OP_W-1:0]  ir_op_i,
   input  logic [XOP_W-1:0] ir_xop_i,
   input  logic [CC_W-1:0]  ir_cc_i,
   input  logic             flag_z_i,
   input  logic             flag_s_i,
   input  logic             mem_rdy_i,
   output logic [UA_W-1:0]  uaddr_o,
   output logic [2:0]       dst_o,
   output logic [2:0]       src_o,
   output logic [2:0]       rsel_o,
   output logic             opmux_o,
   output logic [2:0]       alu_o,
   output logic [1:0]       mem_o,
   output logic             pc_inc_o,
   output logic             exc_o
);

   generate
      if (OP_W < 3) begin : g_bad_op
         $error("useq_ctrl: OP_W must be at least 3");
      end
      if (XOP_W < 4) begin : g_bad_xop
         $error("useq_ctrl: XOP_W must be at least 4");
      end
      if (CC_W < 3) begin : g_bad_cc
         $error("useq_ctrl: CC_W must be at least 3");
      end
      if ((1 << UA_W) < CS_DEPTH) begin : g_bad_ua
         $error("useq_ctrl: micro-address too narrow for the control store");
      end
   endgenerate

   logic [UA_W-1:0] upc_q, upc_d, disp_tgt;
   logic            exc_q, cc_ok;
   uword_t          w;

   useq_store #(.DEPTH(CS_DEPTH), .TABLE(CS_TABLE)) u_store (
      .addr_i (upc_q),
      .word_o (w)
   );

   useq_dispatch #(.OP_W(OP_W), .XOP_W(XOP_W)) u_disp (
      .op_i  (ir_op_i),
      .xop_i (ir_xop_i),
      .tgt_o (disp_tgt)
   );

   useq_cond #(.CC_W(CC_W)) u_cond (
      .code_i (ir_cc_i),
      .z_i    (flag_z_i),
      .s_i    (flag_s_i),
      .ok_o   (cc_ok)
   );

   always_comb begin
      case (w.seq)
         SQ_NEXT:   upc_d = upc_q + 1'b1;
         SQ_WAIT:   upc_d = mem_rdy_i ? upc_q + 1'b1 : upc_q;
         SQ_DECODE: upc_d = disp_tgt;
         SQ_TEST:   upc_d = cc_ok ? upc_q + 1'b1 : w.tgt;
         SQ_JUMP:   upc_d = w.tgt;
         default:   upc_d = UA_W'(UA_FETCH);
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         upc_q <= UA_W'(UA_FETCH);
         exc_q <= 1'b0;
      end else begin
         upc_q <= upc_d;
         if (w.misc == MS_EXC) exc_q <= 1'b1;
      end
   end

   assign uaddr_o  = upc_q;
   assign dst_o    = w.dst;
   assign src_o    = w.src;
   assign rsel_o   = w.rsel;
   assign opmux_o  = w.mux;
   assign alu_o    = w.alu;
   assign mem_o    = w.mem;
   assign pc_inc_o = (w.misc == MS_PCINC);
   assign exc_o    = exc_q;

endmodule

// File: rtl/useq_ctrl_chk.sv
module useq_ctrl_chk
   import useq_pkg::*;
(
   input logic            clk,
   input logic            rst_n,
   input logic            mem_rdy_i,
   input logic [UA_W-1:0] uaddr_o,
   input logic [2:0]      dst_o,
   input logic            opmux_o,
   input logic [2:0]      alu_o,
   input logic [1:0]      mem_o,
   input logic            pc_inc_o,
   input logic            exc_o
);

   // R2
   fetch_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (uaddr_o == UA_W'(UA_FETCH)) |=> (uaddr_o == UA_W'(UA_FETCH + 1)));

   // R2
   pcinc_ir_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pc_inc_o |-> (dst_o == DST_IR));

   // R6
   mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_o != MC_IDLE && !mem_rdy_i) |=> ($stable(uaddr_o) && $stable(mem_o)));

   // R6
   mem_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_o != MC_IDLE && mem_rdy_i) |=> (uaddr_o == $past(uaddr_o) + 1'b1));

   // R5
   exc_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      exc_o |=> exc_o);

   // R5
   exc_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(exc_o) |-> ($past(uaddr_o) == UA_W'(UA_EXC)));

   // R7
   jmp_branch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (uaddr_o == UA_W'(UA_JMP)) |=> (uaddr_o == UA_W'(UA_JMP + 1) || uaddr_o == UA_W'(UA_FETCH)));

   // R8
   bus_operand_chk: assert property (@(posedge clk) disable iff (!rst_n)
      opmux_o |-> (alu_o == AL_ADD));

endmodule

bind useq_ctrl useq_ctrl_chk u_chk (.*);

// File: tb/useq_ctrl_test.sv
module useq_ctrl_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] op = '0;
   logic [3:0] xop = '0;
   logic [2:0] cc = '0;
   logic       fz = 1'b0, fs = 1'b0, rdy = 1'b0, idle_rdy = 1'b0;
   logic       exp_exc = 1'b0;
   logic       done = 1'b0;

   logic [5:0] uaddr;
   logic [2:0] dst, src, rsel, alu;
   logic       opmux, pc_inc, exc;
   logic [1:0] mem;

   int n_cmp = 0;
   int n_bad = 0;

   typedef struct {
      logic [22:0] v;
      string       req;
   } item_t;
   item_t q[$];
   item_t cur;

   always #10 clk = ~clk;   // 50 MHz

   useq_ctrl uut (
      .clk(clk), .rst_n(rst_n), .ir_op_i(op), .ir_xop_i(xop), .ir_cc_i(cc),
      .flag_z_i(fz), .flag_s_i(fs), .mem_rdy_i(rdy), .uaddr_o(uaddr),
      .dst_o(dst), .src_o(src), .rsel_o(rsel), .opmux_o(opmux), .alu_o(alu),
      .mem_o(mem), .pc_inc_o(pc_inc), .exc_o(exc)
   );

   wire [22:0] obs = {uaddr, dst, src, rsel, opmux, alu, mem, pc_inc, exc};

   // monitor: compares one expected item per cycle, in the low phase
   always @(negedge clk) begin
      #2;
      if (q.size() > 0) begin
         cur = q.pop_front();
         n_cmp++;
         if (obs !== cur.v) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", cur.req, obs, cur.v);
         end
      end
   end

   task automatic push(int ua, int d, int s, int r, int m, int a, int mc, int inc,
                       logic rdy_v, string req);
      item_t it;
      @(negedge clk);
      rdy = rdy_v;
      it.v = {6'(ua), 3'(d), 3'(s), 3'(r), 1'(m), 3'(a), 2'(mc), 1'(inc), exp_exc};
      it.req = req;
      q.push_back(it);
   endtask

   task automatic st(int ua, int d, int s, int r, int m, int a, string req);
      push(ua, d, s, r, m, a, 0, 0, idle_rdy, req);
   endtask

   task automatic mst(int ua, int mc, int waits, string req);
      for (int i = 0; i < waits; i++) push(ua, 0, 0, 0, 0, 0, mc, 0, 1'b0, req);
      push(ua, 0, 0, 0, 0, 0, mc, 0, 1'b1, req);
   endtask

   task automatic fetch(logic [15:0] insn, int waits, string req0);
      idle_rdy = ~idle_rdy;
      st(0, 1, 1, 0, 0, 0, req0);
      op  = insn[15:13];
      xop = insn[12:9];
      cc  = insn[12:10];
      mst(1, 1, waits, "R2");
      push(2, 3, 4, 0, 0, 0, 0, 1, idle_rdy, "R2");
   endtask

   function automatic logic [15:0] lf(int o, int r0, int ads);
      return {3'(o), 3'(r0), 10'(ads)};
   endfunction

   function automatic logic [15:0] sf(int x, int r1, int r2, int d);
      return {3'd7, 4'(x), 3'(r1), 3'(r2), 3'(d)};
   endfunction

   function automatic logic cc_true(int c, logic z, logic s);
      case (c)
         0: return 1'b1;
         1: return z;
         2: return !z;
         3: return s;
         4: return s || z;
         5: return !s || !z;
         6: return !s;
         default: return 1'b0;
      endcase
   endfunction

   task automatic do_reset();
      @(posedge clk);
      #5 rst_n = 1'b0;
      exp_exc = 1'b0;
      st(0, 1, 1, 0, 0, 0, "R1");
      #15 rst_n = 1'b1;
   endtask

   task automatic t_exc(logic [15:0] insn);
      fetch(insn, 0, "R2");
      st(34, 0, 0, 0, 0, 0, "R5");
      exp_exc = 1'b1;
   endtask

   task automatic t_jmp(int c, logic z, logic s);
      fetch(lf(2, c, 5), 0, "R3");
      fz = z;
      fs = s;
      st(24, 0, 0, 0, 0, 0, "R7");
      if (cc_true(c, z, s)) st(25, 4, 2, 0, 0, 0, "R7");
   endtask

   initial begin
      repeat (2) @(negedge clk);
      do_reset();

      // load / store with wait states
      fetch(lf(0, 2, 100), 0, "R1");
      st(3, 1, 2, 0, 0, 0, "R10");
      mst(4, 1, 2, "R6");
      st(5, 5, 4, 1, 0, 0, "R10");

      fetch(lf(1, 3, 7), 1, "R3");
      st(6, 1, 2, 0, 0, 0, "R10");
      st(7, 2, 3, 1, 0, 0, "R10");
      mst(8, 2, 3, "R6");
      st(9, 0, 0, 0, 0, 0, "R10");

      // conditional jumps over every code and flag pair
      for (int c = 0; c < 8; c++)
         for (int f = 0; f < 4; f++)
            t_jmp(c, f[1], f[0]);

      // jal, jr
      fetch(lf(3, 4, 9), 0, "R3");
      st(26, 5, 1, 1, 0, 0, "R9");
      st(27, 4, 2, 0, 0, 0, "R9");
      fetch(sf(6, 1, 0, 0), 0, "R4");
      st(28, 4, 3, 2, 0, 0, "R9");

      // register forms
      fetch(sf(0, 1, 2, 0), 0, "R4");
      st(17, 0, 0, 2, 0, 1, "R11");
      st(18, 5, 5, 3, 0, 0, "R11");
      fetch(sf(1, 1, 2, 0), 1, "R4");
      st(10, 1, 3, 2, 0, 0, "R10");
      mst(11, 1, 1, "R6");
      st(12, 5, 4, 3, 0, 0, "R10");
      fetch(sf(2, 3, 4, 0), 0, "R4");
      st(13, 1, 3, 3, 0, 0, "R10");
      st(14, 2, 3, 2, 0, 0, "R10");
      mst(15, 2, 0, "R6");
      st(16, 0, 0, 0, 0, 0, "R10");
      fetch(sf(3, 1, 2, 0), 0, "R4");
      st(19, 0, 0, 4, 0, 2, "R11");
      st(20, 5, 5, 2, 0, 0, "R11");
      fetch(sf(4, 1, 2, 0), 0, "R4");
      st(21, 0, 0, 4, 0, 3, "R11");
      fetch(sf(5, 6, 0, 0), 0, "R4");
      st(22, 0, 0, 2, 0, 4, "R11");
      st(23, 5, 5, 2, 0, 0, "R11");

      // register plus displacement add, with and without waits
      for (int w = 0; w < 3; w += 2) begin
         fetch(sf(7, 1, 2, 5), w, "R4");
         st(29, 0, 6, 3, 1, 2, "R8");
         st(30, 1, 5, 0, 0, 0, "R8");
         mst(31, 1, w, "R8");
         st(32, 0, 4, 2, 1, 2, "R8");
         st(33, 5, 5, 2, 0, 0, "R8");
      end

      // trap, undefined codes; flag stays set across a normal instruction
      t_exc(sf(8, 0, 0, 0));
      fetch(sf(4, 1, 2, 0), 0, "R5");
      st(21, 0, 0, 4, 0, 3, "R5");
      for (int o = 4; o < 7; o++) t_exc(lf(o, 0, 0));
      do_reset();
      for (int x = 9; x < 16; x++) t_exc(sf(x, 0, 0, 0));
      fetch(lf(0, 1, 1), 0, "R5");
      do_reset();
      fetch(lf(2, 0, 3), 0, "R1");
      st(24, 0, 0, 0, 0, 0, "R7");
      st(25, 4, 2, 0, 0, 0, "R7");

      @(negedge clk);
      #5;
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL R2: watchdog got no completion expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule